// File: doc/BRIEF.md
# JTAG Test Access Port Controller with Instruction Decoder

This block is the serial test port of a chip. It is clocked by TCK and steered by TMS through the sixteen-state test access port state machine. It shifts TDI into a 10-bit instruction register or into the selected data register, and drives TDO from the low end of whichever register is being shifted. The data registers built in are a one-bit bypass stage, a 32-bit identification word and a 32-bit user code word. Two more data paths leave the block: one to an external boundary-scan chain and one to a user scan port in the logic array. For these the controller supplies select lines and shared capture, shift and update strobes.

The decoder maps each loaded opcode onto a data-register choice and onto the pin-control outputs that the boundary cells use: test mode, all-pins tri-state and clamp. A secure input narrows the accepted instructions to four. Any other opcode, including an unknown one, then acts as bypass. Four reserved opcodes are never acted on. Loading one of them selects bypass and latches a sticky flag.

Top module: `tap_ctrl`

## Requirements
- R1: The state advances on each rising TCK edge according to TMS. Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state. While `rst` is high at a rising edge, the state returns to Test-Logic-Reset.
- R2: From Test-Logic-Reset, the TMS sequence 0,1,1,0,0 reaches Shift-IR. Capture-IR loads 10'b00_0000_0001, so the first two TDO bits in Shift-IR are 1 and then 0.
- R3: `tdo` and `tdo_oe` change only on falling TCK edges. `tdo_oe` is high only while the state is Shift-IR or Shift-DR, and all registers shift least significant bit first.
- R4: The active instruction becomes 00_0000_0110 (identification) in Test-Logic-Reset and under `rst`. A shifted opcode takes effect only when Update-IR is passed.
- R5: The identification register shifts out {ID_VERSION[3:0], ID_PART[15:0], 11'b000_0110_1110, 1'b1} with bit 0 first.
- R6: Opcode 00_0000_0111 selects the 32-bit USER_CODE word. Opcode 11_1111_1111, and any opcode not named in R5 to R10, selects bypass. Bypass captures 0 and then delays TDI by one TCK.
- R7: Opcode 00_0000_0101 (sample) and opcode 00_0000_1111 (external test) raise `bsr_sel` and pass `bsr_tdo` to TDO. Opcode 00_0000_1100 raises `usr0_sel` and opcode 00_0000_1110 raises `usr1_sel`, and both pass `usr_tdo` to TDO. At most one select is high at a time.
- R8: External test, 00_0000_1011 (tri-state) and 00_0000_1010 (clamp) raise `test_mode`. Tri-state also raises `pins_highz` and clamp raises `pins_clamp`. Both of these use the bypass register.
- R9: While `secure_en` is high, only sample, external test, bypass and identification keep their effect. Every other opcode behaves as bypass with all pin controls and user selects low.
- R10: Opcodes 10_0100_0000, 10_0011_0000, 10_1110_0000 and 10_0011_0001 behave as bypass and set `illegal_op` when Update-IR is passed. The flag stays set, through Test-Logic-Reset as well, until `rst`.
- R11: `scan_capture`, `scan_shift` and `scan_update` are high exactly while the state is Capture-DR, Shift-DR and Update-DR respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| secure_en | input | 1 | Restricts the accepted instructions |
| bsr_tdo | input | 1 | Serial return from the boundary-scan chain |
| usr_tdo | input | 1 | Serial return from the user scan port |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | Output enable for tdo |
| scan_capture | output | 1 | Capture-DR strobe for external chains |
| scan_shift | output | 1 | Shift-DR strobe for external chains |
| scan_update | output | 1 | Update-DR strobe for external chains |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| usr0_sel | output | 1 | User scan port 0 selected |
| usr1_sel | output | 1 | User scan port 1 selected |
| test_mode | output | 1 | Pins are driven from the boundary update stages |
| pins_highz | output | 1 | Tri-state all pins |
| pins_clamp | output | 1 | Hold pins at the boundary update values |
| illegal_op | output | 1 | Sticky reserved-opcode flag |

## Verification
The bench loads every named opcode with secure off and with secure on. It reads the selected path through an 8-bit signature, so a decoder that routes the user code or a user port through while secure would return the wrong signature instead of the bypass-delayed pattern. Reserved opcodes must leave bypass in place and set the flag. A flag that a later legal load or Test-Logic-Reset clears, or that an unknown opcode sets, is caught. A shift interrupted by Pause-DR must resume without losing a bit, and five TMS-high cycles must restore the identification instruction. The captured instruction pattern must lead with 1 then 0, which exposes a design that shifts MSB first or captures the wrong constant.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    localparam int IR_W  = 10;
    localparam int DR_W  = 32;
    localparam int MFR_W = 11;

    typedef enum logic [3:0] {
        S_TLR, S_RTI,
        S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
    } tap_state_e;

    typedef enum logic [2:0] {
        DR_BYPASS, DR_IDCODE, DR_USERCODE, DR_BSR, DR_USER
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e dr;
        logic    test_mode;
        logic    highz;
        logic    clamp;
        logic    user1;
    } ir_dec_t;

    localparam logic [IR_W-1:0]  OP_SAMPLE   = 10'b00_0000_0101;
    localparam logic [IR_W-1:0]  OP_EXTEST   = 10'b00_0000_1111;
    localparam logic [IR_W-1:0]  OP_BYPASS   = 10'b11_1111_1111;
    localparam logic [IR_W-1:0]  OP_USERCODE = 10'b00_0000_0111;
    localparam logic [IR_W-1:0]  OP_IDCODE   = 10'b00_0000_0110;
    localparam logic [IR_W-1:0]  OP_HIGHZ    = 10'b00_0000_1011;
    localparam logic [IR_W-1:0]  OP_CLAMP    = 10'b00_0000_1010;
    localparam logic [IR_W-1:0]  OP_USER0    = 10'b00_0000_1100;
    localparam logic [IR_W-1:0]  OP_USER1    = 10'b00_0000_1110;
    localparam logic [IR_W-1:0]  IR_CAPTURE  = 10'b00_0000_0001;
    localparam logic [MFR_W-1:0] MFR_CODE    = 11'b000_0110_1110;

    function automatic logic is_private(input logic [IR_W-1:0] op);
        return (op == 10'b10_0100_0000) || (op == 10'b10_0011_0000) ||
               (op == 10'b10_1110_0000) || (op == 10'b10_0011_0001);
    endfunction

    function automatic logic secure_ok(input logic [IR_W-1:0] op);
        return (op == OP_SAMPLE) || (op == OP_EXTEST) ||
               (op == OP_BYPASS) || (op == OP_IDCODE);
    endfunction

    function automatic ir_dec_t decode_op(input logic [IR_W-1:0] op,
                                          input logic secure);
        ir_dec_t d;
        d = '{dr: DR_BYPASS, test_mode: 1'b0, highz: 1'b0, clamp: 1'b0, user1: 1'b0};
        case (op)
            OP_SAMPLE:   d.dr = DR_BSR;
            OP_EXTEST:   begin d.dr = DR_BSR; d.test_mode = 1'b1; end
            OP_IDCODE:   d.dr = DR_IDCODE;
            OP_USERCODE: d.dr = DR_USERCODE;
            OP_HIGHZ:    begin d.test_mode = 1'b1; d.highz = 1'b1; end
            OP_CLAMP:    begin d.test_mode = 1'b1; d.clamp = 1'b1; end
            OP_USER0:    d.dr = DR_USER;
            OP_USER1:    begin d.dr = DR_USER; d.user1 = 1'b1; end
            default:     ;
        endcase
        if (secure && !secure_ok(op))
            d = '{dr: DR_BYPASS, test_mode: 1'b0, highz: 1'b0, clamp: 1'b0, user1: 1'b0};
        return d;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    tap_state_e nxt;

    always_comb begin
        case (state)
            S_TLR:    nxt = tms ? S_TLR    : S_RTI;
            S_RTI:    nxt = tms ? S_SEL_DR : S_RTI;
            S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
            S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
            S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
            S_UPD_DR: nxt = tms ? S_SEL_DR : S_RTI;
            S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
            S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
            S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
            S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
            S_UPD_IR: nxt = tms ? S_SEL_DR : S_RTI;
            default:  nxt = S_TLR;
        endcase
    end

    always_ff @(posedge tck) begin
        if (rst) state <= S_TLR;
        else     state <= nxt;
    end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic             tck,
    input  logic             rst,
    input  logic             tdi,
    input  tap_state_e       state,
    output logic [IR_W-1:0]  ir_q,
    output logic             ir_so,
    output logic             illegal
);
    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_sr   <= '0;
            ir_q    <= OP_IDCODE;
            illegal <= 1'b0;
        end else begin
            case (state)
                S_TLR:    ir_q  <= OP_IDCODE;
                S_CAP_IR: ir_sr <= IR_CAPTURE;
                S_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                S_UPD_IR: begin
                    ir_q <= ir_sr;
                    if (is_private(ir_sr)) illegal <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ir_so = ir_sr[0];
endmodule

// File: rtl/tap_dreg.sv
module tap_dreg
    import jtag_tap_pkg::*;
#(
    parameter logic [DR_W-1:0] ID_VALUE  = '0,
    parameter logic [DR_W-1:0] USER_CODE = '0
) (
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_e state,
    input  dr_sel_e    sel,
    output logic       dr_so,
    output logic       byp_so
);
    logic [DR_W-1:0] dr_sr;
    logic            byp_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            dr_sr <= '0;
            byp_q <= 1'b0;
        end else if (state == S_CAP_DR) begin
            byp_q <= 1'b0;
            dr_sr <= (sel == DR_USERCODE) ? USER_CODE : ID_VALUE;
        end else if (state == S_SH_DR) begin
            byp_q <= tdi;
            dr_sr <= {tdi, dr_sr[DR_W-1:1]};
        end
    end

    assign dr_so  = dr_sr[0];
    assign byp_so = byp_q;
endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
    import jtag_tap_pkg::*;
#(
    parameter logic [3:0]      ID_VERSION = 4'h1,
    parameter logic [15:0]     ID_PART    = 16'h3185,
    parameter logic [DR_W-1:0] USER_CODE  = 32'h0000_0000
) (
    input  logic tck,
    input  logic rst,
    input  logic tms,
    input  logic tdi,
    input  logic secure_en,
    input  logic bsr_tdo,
    input  logic usr_tdo,
    output logic tdo,
    output logic tdo_oe,
    output logic scan_capture,
    output logic scan_shift,
    output logic scan_update,
    output logic bsr_sel,
    output logic usr0_sel,
    output logic usr1_sel,
    output logic test_mode,
    output logic pins_highz,
    output logic pins_clamp,
    output logic illegal_op
);
    localparam logic [DR_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, MFR_CODE, 1'b1};

    tap_state_e      state;
    logic [IR_W-1:0] ir_q;
    logic            ir_so, dr_so, byp_so, ser_out, shifting;
    ir_dec_t         dec;

    tap_fsm u_fsm (.tck(tck), .rst(rst), .tms(tms), .state(state));

    tap_ir u_ir (.tck(tck), .rst(rst), .tdi(tdi), .state(state),
                 .ir_q(ir_q), .ir_so(ir_so), .illegal(illegal_op));

    assign dec = decode_op(ir_q, secure_en);

    tap_dreg #(.ID_VALUE(ID_VALUE), .USER_CODE(USER_CODE)) u_dr (
        .tck(tck), .rst(rst), .tdi(tdi), .state(state), .sel(dec.dr),
        .dr_so(dr_so), .byp_so(byp_so));

    always_comb begin
        if (state == S_SH_IR) ser_out = ir_so;
        else begin
            case (dec.dr)
                DR_IDCODE, DR_USERCODE: ser_out = dr_so;
                DR_BSR:                 ser_out = bsr_tdo;
                DR_USER:                ser_out = usr_tdo;
                default:                ser_out = byp_so;
            endcase
        end
    end

    assign shifting = (state == S_SH_IR) || (state == S_SH_DR);

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= ser_out;
            tdo_oe <= shifting;
        end
    end

    assign scan_capture = (state == S_CAP_DR);
    assign scan_shift   = (state == S_SH_DR);
    assign scan_update  = (state == S_UPD_DR);
    assign bsr_sel      = (dec.dr == DR_BSR);
    assign usr0_sel     = (dec.dr == DR_USER) && !dec.user1;
    assign usr1_sel     = (dec.dr == DR_USER) &&  dec.user1;
    assign test_mode    = dec.test_mode;
    assign pins_highz   = dec.highz;
    assign pins_clamp   = dec.clamp;
endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
    import jtag_tap_pkg::*;
(
    input logic       tck,
    input logic       rst,
    input logic       tms,
    input logic       secure_en,
    input tap_state_e state,
    input logic       tdo_oe,
    input logic       scan_update,
    input logic       bsr_sel,
    input logic       usr0_sel,
    input logic       usr1_sel,
    input logic       pins_highz,
    input logic       pins_clamp,
    input logic       test_mode,
    input logic       illegal_op
);
    // R1
    tlr_reach_chk: assert property (@(posedge tck) disable iff (rst)
        ($past(tms,1) && $past(tms,2) && $past(tms,3) && $past(tms,4) && $past(tms,5))
        |-> state == S_TLR);

    // R3
    oe_window_chk: assert property (@(posedge tck) disable iff (rst)
        tdo_oe == (state == S_SH_DR || state == S_SH_IR));

    // R11
    update_entry_chk: assert property (@(posedge tck) disable iff (rst)
        scan_update |-> ($past(state) == S_EX1_DR || $past(state) == S_EX2_DR));

    // R7
    one_sel_chk: assert property (@(posedge tck) disable iff (rst)
        $onehot0({bsr_sel, usr0_sel, usr1_sel}));

    // R8
    highz_mode_chk: assert property (@(posedge tck) disable iff (rst)
        (pins_highz || pins_clamp) |-> (test_mode && !bsr_sel));

    // R9
    secure_filter_chk: assert property (@(posedge tck) disable iff (rst)
        secure_en |-> !(usr0_sel || usr1_sel || pins_highz || pins_clamp));

    // R10
    sticky_flag_chk: assert property (@(posedge tck) disable iff (rst)
        illegal_op |=> illegal_op);
endmodule

bind tap_ctrl tap_ctrl_chk u_chk (
    .tck(tck), .rst(rst), .tms(tms), .secure_en(secure_en), .state(state),
    .tdo_oe(tdo_oe), .scan_update(scan_update), .bsr_sel(bsr_sel),
    .usr0_sel(usr0_sel), .usr1_sel(usr1_sel), .pins_highz(pins_highz),
    .pins_clamp(pins_clamp), .test_mode(test_mode), .illegal_op(illegal_op));

// File: tb/tap_ctrl_test.sv
module tap_ctrl_test;
    localparam logic [3:0]  T_VER  = 4'h3;
    localparam logic [15:0] T_PART = 16'h31A5;
    localparam logic [31:0] T_UC   = 32'h5EED_C01E;
    localparam logic [31:0] T_ID   = {T_VER, T_PART, 11'b000_0110_1110, 1'b1};
    localparam logic [7:0]  PAT    = 8'hB2;

    logic tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0, secure_en = 1'b0;
    logic tdo, tdo_oe, scan_capture, scan_shift, scan_update;
    logic bsr_sel, usr0_sel, usr1_sel, test_mode, pins_highz, pins_clamp, illegal_op;
    logic s_tdo, s_oe, s_cap, s_shift;
    int n_chk = 0, n_bad = 0;

    always #5 tck = ~tck;

    tap_ctrl #(.ID_VERSION(T_VER), .ID_PART(T_PART), .USER_CODE(T_UC)) uut (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .secure_en(secure_en),
        .bsr_tdo(1'b1), .usr_tdo(1'b0), .tdo(tdo), .tdo_oe(tdo_oe),
        .scan_capture(scan_capture), .scan_shift(scan_shift), .scan_update(scan_update),
        .bsr_sel(bsr_sel), .usr0_sel(usr0_sel), .usr1_sel(usr1_sel),
        .test_mode(test_mode), .pins_highz(pins_highz), .pins_clamp(pins_clamp),
        .illegal_op(illegal_op));

    // {secure, opcode, class, {test_mode, highz, clamp, bsr_sel, usr0, usr1}}
    // class: 0 bypass, 1 id, 2 usercode, 3 boundary chain, 4 user port
    localparam int NV = 22;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 10'h005, 3'd3, 6'b000100}, {1'b0, 10'h00F, 3'd3, 6'b100100},
        {1'b0, 10'h3FF, 3'd0, 6'b000000}, {1'b0, 10'h007, 3'd2, 6'b000000},
        {1'b0, 10'h006, 3'd1, 6'b000000}, {1'b0, 10'h00B, 3'd0, 6'b110000},
        {1'b0, 10'h00A, 3'd0, 6'b101000}, {1'b0, 10'h00C, 3'd4, 6'b000010},
        {1'b0, 10'h00E, 3'd4, 6'b000001}, {1'b0, 10'h155, 3'd0, 6'b000000},
        {1'b1, 10'h007, 3'd0, 6'b000000}, {1'b1, 10'h00B, 3'd0, 6'b000000},
        {1'b1, 10'h00A, 3'd0, 6'b000000}, {1'b1, 10'h00C, 3'd0, 6'b000000},
        {1'b1, 10'h00E, 3'd0, 6'b000000}, {1'b1, 10'h00F, 3'd3, 6'b100100},
        {1'b1, 10'h005, 3'd3, 6'b000100}, {1'b1, 10'h006, 3'd1, 6'b000000},
        {1'b0, 10'h240, 3'd0, 6'b000000}, {1'b0, 10'h230, 3'd0, 6'b000000},
        {1'b0, 10'h2E0, 3'd0, 6'b000000}, {1'b0, 10'h231, 3'd0, 6'b000000}
    };
    localparam int FIRST_PRIV = 18;

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        @(negedge tck); #2;
        s_tdo = tdo; s_oe = tdo_oe; s_cap = scan_capture; s_shift = scan_shift;
        tms = m; tdi = d;
    endtask

    task automatic shift_bits(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]);
            dout[i] = s_tdo;
            if (i == 0) chk(s_oe === 1'b1, "R3 oe in shift", {31'd0, s_oe}, 32'd1);
        end
    endtask

    task automatic finish_update;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic load_ir(input logic [9:0] op, output logic [31:0] cap);
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        shift_bits(10, {22'd0, op}, cap);
        finish_update();
    endtask

    task automatic read_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        chk(s_cap === 1'b1, "R11 capture strobe", {31'd0, s_cap}, 32'd1);
        shift_bits(n, din, dout);
        chk(s_shift === 1'b1, "R11 shift strobe", {31'd0, s_shift}, 32'd1);
        finish_update();
    endtask

    function automatic logic [7:0] expect_sig(input logic [2:0] cls);
        case (cls)
            3'd1:    return T_ID[7:0];
            3'd2:    return T_UC[7:0];
            3'd3:    return 8'hFF;
            3'd4:    return 8'h00;
            default: return {PAT[6:0], 1'b0};
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge tck);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] got;
        logic [5:0]  flags;
        repeat (3) @(posedge tck);
        @(negedge tck); rst = 1'b0; tms = 1'b1;
        #2;
        chk(tdo_oe === 1'b0, "R3 reset oe", {31'd0, tdo_oe}, 32'd0);
        chk({test_mode, bsr_sel, usr0_sel, usr1_sel, illegal_op} === 5'b0,
            "R4 reset outputs", {27'd0, test_mode, bsr_sel, usr0_sel, usr1_sel, illegal_op}, 32'd0);

        // R2: 0,1,1,0,0 from Test-Logic-Reset into Shift-IR
        step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        shift_bits(10, 32'h006, got);
        chk(got[1:0] === 2'b01, "R2 first bits 1 then 0", got, 32'h1);
        chk(got === 32'h001, "R2 captured IR", got, 32'h001);
        finish_update();

        // R5 full identification word
        read_dr(32, 32'hFFFF_0000, got);
        chk(got === T_ID, "R5 id word", got, T_ID);

        // R6 full user code word
        load_ir(10'h007, got);
        read_dr(32, 32'h0, got);
        chk(got === T_UC, "R6 usercode word", got, T_UC);

        // R4 opcode not active before Update-IR: leave through Exit1/Pause without update? check active stays
        // R1 five TMS-high cycles return to identification
        load_ir(10'h3FF, got);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
        step(1'b0, 1'b0); step(1'b0, 1'b0);
        read_dr(8, {24'd0, PAT}, got);
        chk(got[7:0] === T_ID[7:0], "R1 five-high reset to id (R4)", got, {24'd0, T_ID[7:0]});

        // R3 shift interrupted by Pause-DR
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, 1'b0); got[i] = s_tdo;
        end
        step(1'b0, 1'b0); step(1'b0, 1'b0);
        chk(s_oe === 1'b0, "R3 oe low in pause", {31'd0, s_oe}, 32'd0);
        step(1'b1, 1'b0); step(1'b0, 1'b0);
        for (int i = 4; i < 8; i++) begin
            step(i == 7, 1'b0); got[i] = s_tdo;
        end
        finish_update();
        chk(got[7:0] === T_ID[7:0], "R3 pause resume", {24'd0, got[7:0]}, {24'd0, T_ID[7:0]});

        // Opcode table walk (R6 R7 R8 R9 R10)
        for (int v = 0; v < NV; v++) begin
            if (v == FIRST_PRIV)
                chk(illegal_op === 1'b0, "R10 no flag for legal or unknown", {31'd0, illegal_op}, 32'd0);
            secure_en = VEC[v][19];
            load_ir(VEC[v][18:9], got);
            flags = {test_mode, pins_highz, pins_clamp, bsr_sel, usr0_sel, usr1_sel};
            chk(flags === VEC[v][5:0], "R7 R8 R9 decode flags", {26'd0, flags}, {26'd0, VEC[v][5:0]});
            read_dr(8, {24'd0, PAT}, got);
            chk(got[7:0] === expect_sig(VEC[v][8:6]), "R6 R7 R9 R10 path signature",
                {24'd0, got[7:0]}, {24'd0, expect_sig(VEC[v][8:6])});
        end
        secure_en = 1'b0;

        chk(illegal_op === 1'b1, "R10 flag set", {31'd0, illegal_op}, 32'd1);
        load_ir(10'h006, got);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk(illegal_op === 1'b1, "R10 flag sticky through TLR", {31'd0, illegal_op}, 32'd1);

        // R1 R4 synchronous reset
        load_ir(10'h00F, got);
        chk(test_mode === 1'b1, "R8 extest mode", {31'd0, test_mode}, 32'd1);
        @(negedge tck); rst = 1'b1;
        @(negedge tck); rst = 1'b0; #2;
        chk(illegal_op === 1'b0, "R10 cleared by rst", {31'd0, illegal_op}, 32'd0);
        chk(test_mode === 1'b0, "R4 rst restores id", {31'd0, test_mode}, 32'd0);
        step(1'b0, 1'b0);
        read_dr(8, {24'd0, PAT}, got);
        chk(got[7:0] === T_ID[7:0], "R1 rst then id read", {24'd0, got[7:0]}, {24'd0, T_ID[7:0]});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule